// File: doc/BRIEF.md
# Mode-Banked Register File with Hardware Exception Entry

This block is the 32-bit register storage of a processor datapath. The datapath sees sixteen architectural registers, R0 to R15. R13 is used as the stack pointer, R14 as the link register and R15 as the program counter. Behind them sit 31 physical registers. Thirty of them are in a single-write-port array and the program counter is held in its own flop. The copy that an architectural index reaches depends on the mode field of the current status word. Each exception mode has its own stack pointer and link register. Fast-interrupt mode also has private copies of R8 to R12. User and System modes share one register set.

The block also holds the current status word and one saved status word for each of the five exception modes. When an exception request is accepted, it performs the whole entry in a single clock edge:
- the link register of the new mode receives the program counter plus 4;
- the saved status of the new mode receives the old status word;
- the mode changes and the interrupt-disable bits are set;
- the program counter loads the vector address.

Instruction decode, return from an exception and memory access belong to other blocks.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0 and sets `status[7:0]` to 0xD3. This means Supervisor mode (0x13) in bits [4:0], normal-interrupt disable (bit 7) set, and fast-interrupt disable (bit 6) set.
- R2: R0–R7 are one set shared by every mode. R8–R12 are shared by every mode except fast-interrupt mode (mode code 0x11), which has its own five copies.
- R3: R13 and R14 have a private copy in each exception mode: fast interrupt 0x11, normal interrupt 0x12, Supervisor 0x13, abort 0x17, undefined 0x1B. User (0x10) and System (0x1F) share one copy.
- R4: Read ports A and B return the register selected at a clock edge just after that edge. The mode used for the lookup is the one in force before that edge. A write at the same edge is not yet visible.
- R5: Selecting R15 on a read port returns `pc`. A normal write to R15 loads `pc`.
- R6: Request bits are indexed as follows: [0] reset, [1] undefined instruction, [2] software interrupt, [3] prefetch abort, [4] data abort, [5] normal interrupt, [6] fast interrupt. An accepted request loads `pc` with its vector: 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 or 0x1C, in that bit order.
- R7: When several requests are present, the most urgent one is accepted. The order is reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt.
- R8: A normal-interrupt request is ignored while `status[7]` is 1. A fast-interrupt request is ignored while `status[6]` is 1.
- R9: On entry, R14 of the new mode receives the old `pc` plus 4, and the new mode's saved status receives the old `status`. The mode becomes Supervisor for reset and software interrupt, undefined for undefined instruction, abort for either abort, normal interrupt for normal interrupt, and fast interrupt for fast interrupt.
- R10: Every entry sets `status[7]`. Fast-interrupt and reset entries also set `status[6]`. All other status bits keep their value.
- R11: An entry in the same cycle as a normal register write or a status write overrides both. The register write and the status write are dropped.
- R12: A status write in User mode changes only bits [31:24]. In any other mode, a status write replaces the whole word.
- R13: `saved_status` shows the saved status of the current mode, and reads 0 in User or System mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 4 | Architectural index for read port A |
| rd_b_sel | input | 4 | Architectural index for read port B |
| rd_a_data | output | 32 | Registered data from port A |
| rd_b_data | output | 32 | Registered data from port B |
| wr_en | input | 1 | Normal register write enable |
| wr_sel | input | 4 | Architectural index to write |
| wr_data | input | 32 | Write data |
| st_wr_en | input | 1 | Status word write enable |
| st_wr_data | input | 32 | New status word |
| exc_req | input | 7 | Exception request bits (see R6) |
| pc | output | 32 | Program counter |
| status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of the current mode |

## Verification
The assertions assume that the mode field of the status word always holds one of the seven defined codes. A status write with any other mode value would make the banking and saved-status checks meaningless, so the stimulus only ever writes defined mode codes. The assertions also assume that no request is accepted while `rst` is high, and the bench raises requests only after reset has been released. User mode is entered only by a status write from a privileged mode, and the bench leaves it only through a software-interrupt request, as a processor would.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam int NUM_ARCH  = 16;
  localparam int NUM_PHYS  = 30;   // excludes the program counter
  localparam int PHYS_W    = $clog2(NUM_PHYS);
  localparam int NUM_EXC   = 7;
  localparam int NUM_SAVED = 5;
  localparam int IBIT      = 7;
  localparam int FBIT      = 6;

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  localparam logic [2:0] EXC_RESET = 3'd0;
  localparam logic [2:0] EXC_UNDEF = 3'd1;
  localparam logic [2:0] EXC_SWI   = 3'd2;
  localparam logic [2:0] EXC_PABT  = 3'd3;
  localparam logic [2:0] EXC_DABT  = 3'd4;
  localparam logic [2:0] EXC_IRQ   = 3'd5;
  localparam logic [2:0] EXC_FIQ   = 3'd6;

  // Group of the private R13/R14 pair; User, System and unknown codes share group 0
  function automatic logic [PHYS_W-1:0] sp_group(input logic [4:0] mode);
    case (mode)
      MODE_FIQ: return PHYS_W'(1);
      MODE_IRQ: return PHYS_W'(2);
      MODE_SVC: return PHYS_W'(3);
      MODE_ABT: return PHYS_W'(4);
      MODE_UND: return PHYS_W'(5);
      default:  return PHYS_W'(0);
    endcase
  endfunction

  // Physical slot for an architectural index R0..R14 in a given mode
  function automatic logic [PHYS_W-1:0] phys_idx(input logic [3:0] r, input logic [4:0] mode);
    logic [PHYS_W-1:0] rr;
    rr = PHYS_W'(r);
    if (r < 4'd8)
      return rr;
    else if (r < 4'd13)
      return (mode == MODE_FIQ) ? rr + PHYS_W'(5) : rr;
    else
      return PHYS_W'(18) + (sp_group(mode) << 1) + (rr - PHYS_W'(13));
  endfunction

  // Saved-status slot of an exception mode; 7 means none
  function automatic logic [2:0] saved_slot(input logic [4:0] mode);
    case (mode)
      MODE_FIQ: return 3'd0;
      MODE_IRQ: return 3'd1;
      MODE_SVC: return 3'd2;
      MODE_ABT: return 3'd3;
      MODE_UND: return 3'd4;
      default:  return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/rf_exc_arbiter.sv
`timescale 1ns/1ps
module rf_exc_arbiter
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NUM_EXC-1:0] req,
  input  logic               irq_off,
  input  logic               fiq_off,
  output logic               take,
  output logic [NUM_EXC-1:0] grant,
  output logic [DATA_W-1:0]  vector,
  output logic [4:0]         new_mode,
  output logic               set_f
);
  localparam int ORDER [NUM_EXC] = '{0, 4, 6, 5, 3, 1, 2};

  logic [NUM_EXC-1:0] eff;
  logic [2:0]         code;

  always_comb begin
    logic found;
    eff = req;
    eff[EXC_IRQ] = req[EXC_IRQ] & ~irq_off;
    eff[EXC_FIQ] = req[EXC_FIQ] & ~fiq_off;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_EXC; i++) begin
      if (!found && eff[ORDER[i]]) begin
        grant[ORDER[i]] = 1'b1;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_EXC; i++)
      if (grant[i]) code = 3'(i);
  end

  assign take   = |grant;
  // vectors step by four, with one unused word between data abort and normal interrupt
  assign vector = (code < EXC_IRQ) ? DATA_W'({code, 2'b00})
                                   : DATA_W'({code, 2'b00}) + DATA_W'(4);

  always_comb begin
    case (code)
      EXC_UNDEF:           new_mode = MODE_UND;
      EXC_PABT, EXC_DABT:  new_mode = MODE_ABT;
      EXC_IRQ:             new_mode = MODE_IRQ;
      EXC_FIQ:             new_mode = MODE_FIQ;
      default:             new_mode = MODE_SVC;
    endcase
  end

  assign set_f = (code == EXC_RESET) || (code == EXC_FIQ);
endmodule

// File: rtl/rf_gpr_array.sv
`timescale 1ns/1ps
module rf_gpr_array #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr [NRD],
  output logic [DATA_W-1:0] rdata [NRD]
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/rf_status.sv
`timescale 1ns/1ps
module rf_status
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              entry,
  input  logic [4:0]        new_mode,
  input  logic              set_f,
  input  logic              st_we,
  input  logic [DATA_W-1:0] st_wdata,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] saved
);
  logic [DATA_W-1:0] cpsr_q;
  logic [DATA_W-1:0] spsr_q [NUM_SAVED];
  logic [2:0]        slot_new, slot_cur;

  assign slot_new = saved_slot(new_mode);
  assign slot_cur = saved_slot(cpsr_q[4:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr_q <= '0;
      cpsr_q[4:0] <= MODE_SVC;
      cpsr_q[IBIT] <= 1'b1;
      cpsr_q[FBIT] <= 1'b1;
    end else if (entry) begin
      cpsr_q[4:0]  <= new_mode;
      cpsr_q[IBIT] <= 1'b1;
      if (set_f) cpsr_q[FBIT] <= 1'b1;
    end else if (st_we) begin
      if (cpsr_q[4:0] == MODE_USR)
        cpsr_q[DATA_W-1:DATA_W-8] <= st_wdata[DATA_W-1:DATA_W-8];
      else
        cpsr_q <= st_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && entry && slot_new < 3'(NUM_SAVED))
      spsr_q[slot_new] <= cpsr_q;
  end

  assign status = cpsr_q;
  assign saved  = (slot_cur < 3'(NUM_SAVED)) ? spsr_q[slot_cur] : '0;
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NRD   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         rd_a_sel,
  input  logic [3:0]         rd_b_sel,
  output logic [DATA_W-1:0]  rd_a_data,
  output logic [DATA_W-1:0]  rd_b_data,
  input  logic               wr_en,
  input  logic [3:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               st_wr_en,
  input  logic [DATA_W-1:0]  st_wr_data,
  input  logic [NUM_EXC-1:0] exc_req,
  output logic [DATA_W-1:0]  pc,
  output logic [DATA_W-1:0]  status,
  output logic [DATA_W-1:0]  saved_status
);
  logic [4:0]         cur_mode;
  logic               take, entry, set_f;
  logic [NUM_EXC-1:0] grant;
  logic [DATA_W-1:0]  exc_vec;
  logic [4:0]         exc_mode;
  logic               gpr_we;
  logic [PHYS_W-1:0]  gpr_waddr;
  logic [DATA_W-1:0]  gpr_wdata;
  logic [3:0]         rd_sel   [NRD];
  logic [PHYS_W-1:0]  rd_addr  [NRD];
  logic [DATA_W-1:0]  rd_mem   [NRD];
  logic [DATA_W-1:0]  rd_out   [NRD];
  logic [DATA_W-1:0]  pc_q;

  assign cur_mode = status[4:0];

  rf_exc_arbiter #(.DATA_W(DATA_W)) u_arb (
    .req(exc_req), .irq_off(status[IBIT]), .fiq_off(status[FBIT]),
    .take(take), .grant(grant), .vector(exc_vec),
    .new_mode(exc_mode), .set_f(set_f)
  );

  assign entry = take & ~rst;

  rf_status #(.DATA_W(DATA_W)) u_st (
    .clk(clk), .rst(rst), .entry(entry), .new_mode(exc_mode), .set_f(set_f),
    .st_we(st_wr_en), .st_wdata(st_wr_data),
    .status(status), .saved(saved_status)
  );

  // Single array write port: exception entry (link register) wins over a normal write
  assign gpr_we    = entry | (wr_en & (wr_sel != 4'd15) & ~rst);
  assign gpr_waddr = entry ? phys_idx(4'd14, exc_mode) : phys_idx(wr_sel, cur_mode);
  assign gpr_wdata = entry ? pc_q + DATA_W'(4) : wr_data;

  always_ff @(posedge clk) begin
    if (rst)                          pc_q <= '0;
    else if (entry)                   pc_q <= exc_vec;
    else if (wr_en && wr_sel == 4'd15) pc_q <= wr_data;
  end
  assign pc = pc_q;

  assign rd_sel[0] = rd_a_sel;
  assign rd_sel[1] = rd_b_sel;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic              is_pc_q;
    logic [DATA_W-1:0] pc_snap_q;
    assign rd_addr[p] = phys_idx(rd_sel[p], cur_mode);
    always_ff @(posedge clk) begin
      is_pc_q   <= (rd_sel[p] == 4'd15);
      pc_snap_q <= pc_q;
    end
    assign rd_out[p] = is_pc_q ? pc_snap_q : rd_mem[p];
  end

  rf_gpr_array #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS), .NRD(NRD)) u_gpr (
    .clk(clk), .we(gpr_we), .waddr(gpr_waddr), .wdata(gpr_wdata),
    .raddr(rd_addr), .rdata(rd_mem)
  );

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              entry,
  input logic [6:0]        grant,
  input logic [DATA_W-1:0] vec,
  input logic [4:0]        new_mode,
  input logic [DATA_W-1:0] pc,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] saved_status,
  input logic              st_wr_en
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && status[7:0] == 8'hD3));

  // R6
  pc_vector_chk: assert property (@(posedge clk) disable iff (rst)
    entry |=> pc == $past(vec));

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R9
  mode_switch_chk: assert property (@(posedge clk) disable iff (rst)
    entry |=> status[4:0] == $past(new_mode));

  // R9
  save_status_chk: assert property (@(posedge clk) disable iff (rst)
    entry |=> saved_status == $past(status));

  // R10
  irq_mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    entry |=> status[7]);

  // R12
  user_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (!entry && st_wr_en && status[4:0] == 5'h10) |=> status[DATA_W-9:0] == $past(status[DATA_W-9:0]));
endmodule

bind banked_regfile rf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .entry(entry), .grant(grant), .vec(exc_vec),
  .new_mode(exc_mode), .pc(pc), .status(status), .saved_status(saved_status),
  .st_wr_en(st_wr_en)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_sel = '0, rd_b_sel = '0;
  logic [31:0] rd_a_data, rd_b_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        st_wr_en = 1'b0;
  logic [31:0] st_wr_data = '0;
  logic [6:0]  exc_req = '0;
  logic [31:0] pc, status, saved_status;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model [32];

  banked_regfile u0 (
    .clk, .rst, .rd_a_sel, .rd_b_sel, .rd_a_data, .rd_b_data,
    .wr_en, .wr_sel, .wr_data, .st_wr_en, .st_wr_data, .exc_req,
    .pc, .status, .saved_status
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // bench view of banking per R2/R3
  function automatic int key(input logic [4:0] m, input int r);
    int g;
    case (m)
      5'h11: g = 1; 5'h12: g = 2; 5'h13: g = 3; 5'h17: g = 4; 5'h1B: g = 5;
      default: g = 0;
    endcase
    if (r < 8) return r;
    if (r < 13) return (m == 5'h11) ? 13 + (r - 8) : r;
    return 18 + 2 * g + (r - 13);
  endfunction

  function automatic logic [31:0] vec_of(input int k);
    return (k < 5) ? 32'(4 * k) : 32'(4 * k + 4);
  endfunction

  function automatic logic [4:0] mode_of(input int k);
    case (k)
      1: return 5'h1B; 3, 4: return 5'h17; 5: return 5'h12; 6: return 5'h11;
      default: return 5'h13;
    endcase
  endfunction

  function automatic int winner(input logic [6:0] m);
    int ord [7] = '{0, 4, 6, 5, 3, 1, 2};
    for (int i = 0; i < 7; i++) if (m[ord[i]]) return ord[i];
    return -1;
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic wr_reg(input int r, input logic [31:0] v);
    wr_en = 1'b1; wr_sel = 4'(r); wr_data = v; tick(); wr_en = 1'b0;
  endtask
  task automatic set_st(input logic [31:0] v);
    st_wr_en = 1'b1; st_wr_data = v; tick(); st_wr_en = 1'b0;
  endtask
  task automatic rd2(input int a, input int b, output logic [31:0] da, output logic [31:0] db);
    rd_a_sel = 4'(a); rd_b_sel = 4'(b); tick(); da = rd_a_data; db = rd_b_data;
  endtask
  task automatic raise(input logic [6:0] m);
    exc_req = m; tick(); exc_req = '0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] a, b, v, expst;
    logic [4:0] modes [6] = '{5'h13, 5'h17, 5'h1B, 5'h12, 5'h11, 5'h1F};
    tick(); tick(); rst = 1'b0; tick();
    chk("R1 pc after reset", pc, 32'h0);
    chk("R1 status after reset", {24'h0, status[7:0]}, 32'hD3);

    // banking sweep over all privileged modes
    for (int mi = 0; mi < 6; mi++) begin
      set_st({27'h0, modes[mi]});
      for (int r = 0; r < 15; r++) begin
        v = {3'(mi), modes[mi], 8'(r), 16'h5A00 ^ 16'(mi * 31 + r)};
        wr_reg(r, v);
        model[key(modes[mi], r)] = v;
      end
    end
    for (int mi = 0; mi < 6; mi++) begin
      set_st({27'h0, modes[mi]});
      for (int r = 0; r < 15; r++) begin
        rd2(r, 14 - r, a, b);
        chk((r < 13) ? "R2 bank read A" : "R3 bank read A", a, model[key(modes[mi], r)]);
        chk((14 - r < 13) ? "R2 bank read B" : "R3 bank read B", b, model[key(modes[mi], 14 - r)]);
      end
    end

    // R13 saved status reads zero in System mode
    chk("R13 saved status in System", saved_status, 32'h0);

    // R4 mode sampled before edge: switch SYS->SVC while reading R13
    rd_a_sel = 4'd13; st_wr_en = 1'b1; st_wr_data = 32'h13; tick(); st_wr_en = 1'b0;
    chk("R4 read uses mode before edge", rd_a_data, model[key(5'h1F, 13)]);
    // R4 read-first on same edge write
    rd_a_sel = 4'd3; wr_en = 1'b1; wr_sel = 4'd3; wr_data = 32'h7777_0003; tick(); wr_en = 1'b0;
    chk("R4 same-edge write not visible", rd_a_data, model[3]);
    tick();
    chk("R4 write visible next read", rd_a_data, 32'h7777_0003);
    model[3] = 32'h7777_0003;

    // R5 program counter access
    wr_reg(15, 32'h0000_1234);
    chk("R5 pc after R15 write", pc, 32'h0000_1234);
    rd2(15, 15, a, b);
    chk("R5 R15 read port A", a, 32'h0000_1234);
    chk("R5 R15 read port B", b, 32'h0000_1234);

    // User mode: shared set, restricted status writes
    set_st(32'h10);
    for (int r = 0; r < 15; r++) begin
      rd2(r, r, a, b);
      chk((r < 13) ? "R2 user read" : "R3 user read", a, model[key(5'h10, r)]);
    end
    chk("R13 saved status in User", saved_status, 32'h0);
    set_st(32'hF000_00DF);
    chk("R12 user status write", status, 32'hF000_0010);
    wr_reg(13, 32'hCAFE_0013);
    model[key(5'h10, 13)] = 32'hCAFE_0013;
    wr_reg(15, 32'h0000_0400);
    raise(7'b000_0100);
    chk("R9 swi from user mode", status, 32'hF000_0093);
    chk("R9 saved user status", saved_status, 32'hF000_0010);
    chk("R6 swi vector", pc, 32'h8);
    set_st(32'h1F);
    rd2(13, 14, a, b);
    chk("R3 System sees User R13", a, 32'hCAFE_0013);
    set_st(32'h13);
    rd2(14, 14, a, b);
    chk("R9 Supervisor link register", a, 32'h0000_0404);

    // each exception on its own
    for (int k = 0; k < 7; k++) begin
      set_st(32'hA000_0013);
      wr_reg(15, 32'(32'h200 + 16 * k));
      raise(7'(1 << k));
      expst = 32'hA000_0080 | ((k == 0 || k == 6) ? 32'h40 : 32'h0) | {27'h0, mode_of(k)};
      chk("R6 vector", pc, vec_of(k));
      chk("R10 status after entry", status, expst);
      chk("R9 saved status", saved_status, 32'hA000_0013);
      rd2(14, 13, a, b);
      chk("R9 link register", a, 32'(32'h204 + 16 * k));
    end

    // priority over every request combination
    for (int m = 1; m < 128; m++) begin
      set_st(32'h13);
      raise(7'(m));
      chk("R7 priority", pc, vec_of(winner(7'(m))));
    end

    // masking
    set_st(32'hD3); wr_reg(15, 32'h300);
    raise(7'b010_0000);
    chk("R8 irq ignored pc", pc, 32'h300);
    chk("R8 irq ignored status", status, 32'hD3);
    set_st(32'h53);
    raise(7'b100_0000);
    chk("R8 fiq ignored pc", pc, 32'h300);
    raise(7'b110_0000);
    chk("R8 irq taken while fiq masked", pc, 32'h18);
    set_st(32'hD3);
    raise(7'b010_0010);
    chk("R8 masked irq lets undef win", pc, 32'h4);

    // entry overrides normal and status writes
    set_st(32'h13);
    wr_reg(0, 32'h1111_1111);
    exc_req = 7'b000_0010; wr_en = 1'b1; wr_sel = 4'd0; wr_data = 32'h2222_2222;
    st_wr_en = 1'b1; st_wr_data = 32'h1F; tick();
    exc_req = '0; wr_en = 1'b0; st_wr_en = 1'b0;
    chk("R11 status write dropped", status, 32'h9B);
    rd2(0, 0, a, b);
    chk("R11 register write dropped", a, 32'h1111_1111);
    set_st(32'h13);
    exc_req = 7'b001_0000; wr_en = 1'b1; wr_sel = 4'd15; wr_data = 32'hDEAD_0000; tick();
    exc_req = '0; wr_en = 1'b0;
    chk("R11 R15 write dropped", pc, 32'h10);

    summary();
  end
endmodule